// File: doc/BRIEF.md
# Received Signal Strength Conversion Sequencer

This block decides when a single signal-strength measurement is taken during a receive session. Once receive is enabled it watches a carrier-detect input, which must stay high without a break for longer than a qualification window (50 µs by default, counted in clock cycles from the clock frequency). When that happens the block asks an external 5-bit converter for one sample through a start pulse. It then waits for the converter's done pulse and stores the returned code, together with a valid flag, in a status byte.

After that one capture the sequencer halts. Nothing changes the stored value until receive enable is dropped and raised again. Dropping receive enable clears the status and sends the sequencer back to idle. For clear-channel checks, firmware can raise a force input, which starts a conversion at once, with or without a carrier. Three decoded flags grade a valid result as low, quiet or strong.

Top module: `rssi_conv_ctrl`

## Requirements
- R1: After reset, `rssi_status` is 0, `adc_start` is 0 and `sig_low`, `sig_quiet` and `sig_strong` are 0.
- R2: While armed, `adc_start` rises one clock after `carrier_det` has been sampled high on QUAL_CYC+1 consecutive armed cycles (QUAL_CYC = CLK_MHZ*QUAL_US). A single low sample restarts the count, and a shorter run starts nothing. The sequencer is armed from the second clock edge at which `rx_en` is seen high.
- R3: `adc_start` is high for exactly one cycle per conversion.
- R4: A `adc_done` pulse during a conversion loads `adc_code` into `rssi_status[4:0]` and sets the valid flag `rssi_status[5]` at the same clock edge. `rssi_status[7:6]` always read 0.
- R5: Once the valid flag is set and `rx_en` stays high, there is no further `adc_start` and `rssi_status` holds, whatever `carrier_det`, `force_cd` and `adc_done` do.
- R6: `rx_en` sampled low clears `rssi_status` to 0 at that edge and aborts any pending conversion. Raising `rx_en` again arms a fresh qualification.
- R7: `force_cd` sampled high while armed starts a conversion at that edge, without any carrier.
- R8: When the valid flag is set: `sig_low` is 1 for codes below LOW_LIMIT (10), `sig_quiet` is 1 for codes up to and including LOW_LIMIT, and `sig_strong` is 1 for codes above STRONG_LIMIT (28). All three flags are 0 while the valid flag is clear.
- R9: A `adc_done` pulse outside a conversion (while armed or halted) leaves `rssi_status` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_en | input | 1 | Receive session enable; a low-then-high toggle rearms the sequencer |
| carrier_det | input | 1 | On-channel carrier above the noise floor |
| force_cd | input | 1 | Firmware force: start a conversion without a carrier |
| adc_done | input | 1 | Converter result strobe |
| adc_code | input | 5 | Converter result, valid with `adc_done` |
| adc_start | output | 1 | One-cycle conversion request |
| rssi_status | output | 8 | [4:0] code, [5] valid, [7:6] zero |
| sig_low | output | 1 | Valid result below the low limit |
| sig_quiet | output | 1 | Valid result at or below the low limit |
| sig_strong | output | 1 | Valid result above the strong limit |

## Verification
The assertions assume the converter answers each start with one done pulse, and that `adc_done` may arrive at any other time only as a stray strobe the block must ignore. They also assume all inputs are synchronous to `clk`. The stimulus drives every input at the falling edge. It sends done pulses only after a start, or deliberately as strays while armed or halted. It drops `rx_en` in the middle of a conversion so the abort path gets exercised.

// File: rtl/rssi_pkg.sv
package rssi_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_QUAL = 2'd1,
    ST_CONV = 2'd2,
    ST_HALT = 2'd3
  } rssi_state_e;

  localparam int CODE_W    = 5;
  localparam int VALID_POS = 5;
  localparam int STATUS_W  = 8;
endpackage

// File: rtl/rssi_rst_sync.sv
module rssi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/rssi_qual_timer.sv
module rssi_qual_timer #(
  parameter int QUAL_CYC = 5000,
  parameter int CNT_W    = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic carrier,
  output logic qual_hit
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_limit;
  logic             cnt_en;

  assign at_limit = (cnt_q == CNT_W'(QUAL_CYC));
  assign cnt_en   = arm | (cnt_q != '0);

  always_comb begin
    qual_hit = arm & carrier & at_limit;
    if (!arm || !carrier || at_limit) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/rssi_seq_fsm.sv
module rssi_seq_fsm
  import rssi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_en,
  input  logic        qual_hit,
  input  logic        force_cd,
  input  logic        adc_done,
  output logic        arm,
  output logic        adc_start,
  output logic        capture
);
  rssi_state_e state_q;
  rssi_state_e state_d;
  logic        launch;

  assign arm     = rx_en & (state_q == ST_QUAL);
  assign launch  = arm & (force_cd | qual_hit);
  assign capture = rx_en & (state_q == ST_CONV) & adc_done;

  always_comb begin
    state_d = state_q;
    if (!rx_en) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:  state_d = ST_QUAL;
        ST_QUAL: if (launch) state_d = ST_CONV;
        ST_CONV: if (adc_done) state_d = ST_HALT;
        ST_HALT: state_d = ST_HALT;
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_OFF;
      adc_start <= 1'b0;
    end else begin
      state_q   <= state_d;
      adc_start <= launch;
    end
  end
endmodule

// File: rtl/rssi_result_reg.sv
module rssi_result_reg
  import rssi_pkg::*;
#(
  parameter int LOW_LIMIT    = 10,
  parameter int STRONG_LIMIT = 28
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                capture,
  input  logic [CODE_W-1:0]   code_in,
  output logic [STATUS_W-1:0] status,
  output logic                sig_low,
  output logic                sig_quiet,
  output logic                sig_strong
);
  localparam logic [CODE_W-1:0] LOW_L    = CODE_W'(LOW_LIMIT);
  localparam logic [CODE_W-1:0] STRONG_L = CODE_W'(STRONG_LIMIT);

  logic [CODE_W-1:0] code_q;
  logic              valid_q;
  logic              ld_en;

  assign ld_en = clear | capture;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      valid_q <= 1'b0;
    end else if (ld_en) begin
      if (clear) begin
        code_q  <= '0;
        valid_q <= 1'b0;
      end else begin
        code_q  <= code_in;
        valid_q <= 1'b1;
      end
    end
  end

  always_comb begin
    status                 = '0;
    status[CODE_W-1:0]     = code_q;
    status[VALID_POS]      = valid_q;
    sig_low                = valid_q & (code_q <  LOW_L);
    sig_quiet              = valid_q & (code_q <= LOW_L);
    sig_strong             = valid_q & (code_q >  STRONG_L);
  end
endmodule

// File: rtl/rssi_conv_ctrl.sv
module rssi_conv_ctrl #(
  parameter int CLK_MHZ      = 100,
  parameter int QUAL_US      = 50,
  parameter int LOW_LIMIT    = 10,
  parameter int STRONG_LIMIT = 28
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       carrier_det,
  input  logic       force_cd,
  input  logic       adc_done,
  input  logic [4:0] adc_code,
  output logic       adc_start,
  output logic [7:0] rssi_status,
  output logic       sig_low,
  output logic       sig_quiet,
  output logic       sig_strong
);
  localparam int QUAL_CYC = CLK_MHZ * QUAL_US;
  localparam int CNT_W    = $clog2(QUAL_CYC + 1);

  logic rst_int_n;
  logic arm;
  logic qual_hit;
  logic capture;

  rssi_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  rssi_qual_timer #(
    .QUAL_CYC (QUAL_CYC),
    .CNT_W    (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .arm      (arm),
    .carrier  (carrier_det),
    .qual_hit (qual_hit)
  );

  rssi_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rx_en     (rx_en),
    .qual_hit  (qual_hit),
    .force_cd  (force_cd),
    .adc_done  (adc_done),
    .arm       (arm),
    .adc_start (adc_start),
    .capture   (capture)
  );

  rssi_result_reg #(
    .LOW_LIMIT    (LOW_LIMIT),
    .STRONG_LIMIT (STRONG_LIMIT)
  ) u_result (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clear      (~rx_en),
    .capture    (capture),
    .code_in    (adc_code),
    .status     (rssi_status),
    .sig_low    (sig_low),
    .sig_quiet  (sig_quiet),
    .sig_strong (sig_strong)
  );
endmodule

// File: rtl/rssi_conv_checker.sv
module rssi_conv_checker #(
  parameter int CLK_MHZ = 100,
  parameter int QUAL_US = 50
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       carrier_det,
  input logic       force_cd,
  input logic       adc_done,
  input logic       adc_start,
  input logic [7:0] rssi_status
);
  localparam int QUAL_CYC = CLK_MHZ * QUAL_US;

  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 0;
    end else if (rx_en && carrier_det) begin
      if (run_q < 32'hFFFF_FFFF) run_q <= run_q + 1;
    end else begin
      run_q <= 0;
    end
  end

  AST_QUAL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_start && !$past(force_cd)) |-> (run_q >= QUAL_CYC + 1)); // R2

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start); // R3

  AST_VALID_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rssi_status[5]) |-> $past(adc_done)); // R4

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rssi_status[5] && rx_en) |=> $stable(rssi_status)); // R5

  AST_HALT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    rssi_status[5] |=> !adc_start); // R5

  AST_RX_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (rssi_status == 8'h00)); // R6
endmodule

bind rssi_conv_ctrl rssi_conv_checker #(
  .CLK_MHZ (CLK_MHZ),
  .QUAL_US (QUAL_US)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_en       (rx_en),
  .carrier_det (carrier_det),
  .force_cd    (force_cd),
  .adc_done    (adc_done),
  .adc_start   (adc_start),
  .rssi_status (rssi_status)
);

// File: tb/test_rssi_conv_ctrl.sv
module test_rssi_conv_ctrl;
  localparam int Q = 100 * 50;

  logic       clk;
  logic       rst_n;
  logic       rx_en;
  logic       carrier_det;
  logic       force_cd;
  logic       adc_done;
  logic [4:0] adc_code;
  logic       adc_start;
  logic [7:0] rssi_status;
  logic       sig_low;
  logic       sig_quiet;
  logic       sig_strong;

  int n_checks = 0;
  int n_err    = 0;
  int n_starts = 0;

  int m_phase = 0;
  int m_cnt   = 0;
  int m_code  = 0;
  bit m_valid = 0;
  bit m_start = 0;

  rssi_conv_ctrl #(.CLK_MHZ(100), .QUAL_US(50)) i_rssi_conv_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .carrier_det(carrier_det),
    .force_cd(force_cd), .adc_done(adc_done), .adc_code(adc_code),
    .adc_start(adc_start), .rssi_status(rssi_status), .sig_low(sig_low),
    .sig_quiet(sig_quiet), .sig_strong(sig_strong)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference, advanced at every rising edge
  always @(posedge clk) begin
    bit nxt_start;
    int exp_status;
    nxt_start = 0;
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_code = 0; m_valid = 0;
    end else if (!rx_en) begin
      m_phase = 0; m_cnt = 0; m_code = 0; m_valid = 0;
    end else begin
      case (m_phase)
        0: begin m_phase = 1; m_cnt = 0; end
        1: begin
          if (force_cd || (carrier_det && m_cnt == Q)) begin
            m_phase = 2; nxt_start = 1; m_cnt = 0;
          end else if (carrier_det) m_cnt++;
          else m_cnt = 0;
        end
        2: if (adc_done) begin m_code = int'(adc_code); m_valid = 1; m_phase = 3; end
        default: ;
      endcase
    end
    m_start = nxt_start;
    #3;
    exp_status = (m_valid ? 32 : 0) + m_code;
    if (adc_start) n_starts++;
    check(int'(rssi_status) == exp_status, "R4 status", int'(rssi_status), exp_status);
    check(adc_start == m_start, "R3 adc_start", int'(adc_start), int'(m_start));
    check(sig_low == (m_valid && m_code < 10), "R8 sig_low", int'(sig_low), int'(m_valid && m_code < 10));
    check(sig_quiet == (m_valid && m_code <= 10), "R8 sig_quiet", int'(sig_quiet), int'(m_valid && m_code <= 10));
    check(sig_strong == (m_valid && m_code > 28), "R8 sig_strong", int'(sig_strong), int'(m_valid && m_code > 28));
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_done(input int code);
    @(negedge clk); adc_done = 1'b1; adc_code = 5'(code);
    @(negedge clk); adc_done = 1'b0; adc_code = 5'd0;
  endtask

  task automatic pulse_force;
    @(negedge clk); force_cd = 1'b1;
    @(negedge clk); force_cd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_en = 1'b0; carrier_det = 1'b0; force_cd = 1'b0;
    adc_done = 1'b0; adc_code = 5'd0;
    step(4);
    rst_n = 1'b1;
    step(5);
    // R1 reset state
    check(rssi_status == 8'h00 && !adc_start, "R1 reset status", int'(rssi_status), 0);
    check(!sig_low && !sig_quiet && !sig_strong, "R1 reset flags",
          int'({sig_low, sig_quiet, sig_strong}), 0);

    // R2 carrier one cycle too short
    rx_en = 1'b1;
    step(2);
    carrier_det = 1'b1;
    step(Q);
    carrier_det = 1'b0;
    step(3);
    check(n_starts == 0, "R2 short carrier", n_starts, 0);
    // R9 stray done while armed
    pulse_done(17);
    step(2);
    check(rssi_status == 8'h00, "R9 stray done", int'(rssi_status), 0);

    // R2/R4 qualified carrier and capture
    carrier_det = 1'b1;
    step(Q + 5);
    check(n_starts == 1, "R2 qualified start", n_starts, 1);
    step(3);
    pulse_done(7);
    check(rssi_status == 8'h27, "R4 capture", int'(rssi_status), 8'h27);
    check(sig_low && sig_quiet && !sig_strong, "R8 low code",
          int'({sig_low, sig_quiet, sig_strong}), 6);

    // R5 halt ignores force and done
    pulse_force();
    pulse_done(31);
    step(20);
    check(n_starts == 1, "R5 no restart", n_starts, 1);
    check(rssi_status == 8'h27, "R5 status held", int'(rssi_status), 8'h27);

    // R6 rearm and R7 forced start
    carrier_det = 1'b0;
    rx_en = 1'b0;
    step(2);
    check(rssi_status == 8'h00, "R6 clear on rx off", int'(rssi_status), 0);
    rx_en = 1'b1;
    step(2);
    pulse_force();
    step(2);
    check(n_starts == 2, "R7 forced start", n_starts, 2);
    pulse_done(30);
    check(rssi_status == 8'h3E, "R4 forced capture", int'(rssi_status), 8'h3E);
    check(sig_strong && !sig_quiet && !sig_low, "R8 strong code",
          int'({sig_low, sig_quiet, sig_strong}), 1);

    // R2 interrupted carrier restarts the count
    rx_en = 1'b0;
    step(2);
    rx_en = 1'b1;
    step(2);
    carrier_det = 1'b1;
    step(Q - 10);
    carrier_det = 1'b0;
    step(1);
    carrier_det = 1'b1;
    step(Q - 10);
    check(n_starts == 2, "R2 interrupted run", n_starts, 2);
    step(20);
    check(n_starts == 3, "R2 second run start", n_starts, 3);

    // R6 abort mid-conversion, R9 late done ignored
    rx_en = 1'b0;
    carrier_det = 1'b0;
    step(2);
    check(rssi_status == 8'h00, "R6 abort", int'(rssi_status), 0);
    rx_en = 1'b1;
    step(2);
    pulse_done(29);
    step(2);
    check(rssi_status == 8'h00, "R9 late done", int'(rssi_status), 0);

    // R8 boundary at the low limit, then R5 halt again
    pulse_force();
    step(2);
    pulse_done(10);
    check(rssi_status == 8'h2A, "R4 boundary capture", int'(rssi_status), 8'h2A);
    check(sig_quiet && !sig_low && !sig_strong, "R8 code at limit",
          int'({sig_low, sig_quiet, sig_strong}), 2);
    pulse_done(9);
    step(2);
    check(rssi_status == 8'h2A, "R5 halted done", int'(rssi_status), 8'h2A);

    step(5);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule